// File: doc/BRIEF.md
# Load-Use and Branch Stall Tracker

This block watches the instruction stream of an in-order core and works out the timing penalty of each issued instruction. Every instruction comes in on an issue strobe with up to two source register fields, a destination field used by loads, a taken flag for control transfers, and one flag per unit class: exec, compare, multiply-accumulate, control transfer, load and store. The block keeps a bitmap of registers whose load result is still outstanding. A source that reads such a register costs a fixed load-use penalty. A taken control transfer costs its own fixed penalty.

The penalty of each instruction is reported one cycle after issue. Four saturating counters are kept: load-stall cycles, control-transfer stall cycles, taken transfers and untaken transfers. A load opens a hazard window that lasts for exactly one following non-store instruction. Stores are transparent to the window. A synchronous clear resets every counter and both bitmaps without a reset pulse.

Top module: `stall_tracker`

## Requirements
- R1: A non-store issue with the load flag makes `pend_map` equal to the one-hot bit of `ld_dst` (bit n for register n). Any other non-store issue makes `pend_map` zero. At the same issue, `act_map` takes the previous `pend_map`.
- R2: Each checked source whose register bit is set in `pend_map` at issue adds LD_PEN (2) cycles to `stall_cyc` and to `ld_stall_cnt`. The two sources are tested independently, so two hits add 4.
- R3: A source field whose top bit is set (for example 5'b11111, the value -1) names no register and never causes a stall.
- R4: Exec, compare and multiply-accumulate issues check both `src_a` and `src_b`. A control transfer checks only `src_a`. Load and store issues check no source.
- R5: A control transfer with `cti_taken` high adds CTI_PEN (2) cycles to `stall_cyc` and to `cti_stall_cnt`, and increments `taken_cnt`. With `cti_taken` low it increments `untaken_cnt` and adds no stall.
- R6: An issue whose only unit flag is store leaves `pend_map` and `act_map` unchanged, so a load is still seen by the first non-store instruction after any number of stores.
- R7: The hazard window is one instruction: a load result is not seen by the second non-store instruction after the load.
- R8: Cycles with `iss_vld` low change no map and no counter, and hold `stall_vld` low.
- R9: Counters stop at 2^CNT_W-1 and never wrap.
- R10: `clr` zeroes all counters, both maps and `stall_vld` on the next edge, and it takes priority over a simultaneous issue.
- R11: After reset, all counters, maps and `stall_vld` are zero.
- R12: `stall_vld` is high and `stall_cyc` is valid in the cycle after each issue, for store issues too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of counters and maps |
| iss_vld | input | 1 | One instruction is issued this cycle |
| u_exec | input | 1 | Exec unit instruction |
| u_cmp | input | 1 | Compare unit instruction |
| u_mac | input | 1 | Multiply-accumulate instruction |
| u_cti | input | 1 | Control transfer instruction |
| u_load | input | 1 | Load instruction |
| u_store | input | 1 | Store instruction |
| cti_taken | input | 1 | Control transfer is taken |
| src_a | input | REG_W+1 | First source register; top bit set means none |
| src_b | input | REG_W+1 | Second source register; top bit set means none |
| ld_dst | input | REG_W | Load destination register |
| stall_vld | output | 1 | `stall_cyc` holds the penalty of the last issue |
| stall_cyc | output | STALL_W | Stall cycles of the last issued instruction |
| pend_map | output | NREG | Registers with loads visible to the next instruction |
| act_map | output | NREG | Map the last non-store instruction was checked against |
| ld_stall_cnt | output | CNT_W | Accumulated load-use stall cycles |
| cti_stall_cnt | output | CNT_W | Accumulated control-transfer stall cycles |
| taken_cnt | output | CNT_W | Taken control transfers |
| untaken_cnt | output | CNT_W | Untaken control transfers |

## Verification
A wrong bit in the pending map shows at the ports on the first issue after the load. That issue reads a penalty that is off by LD_PEN from the expected value, and `ld_stall_cnt` is off by the same amount in the same cycle. `pend_map` also shows the error one cycle after the load. A window that runs too long or is wrongly cleared by a store shows on the second or the post-store consumer. A wrapping counter shows as a drop in value on the first increment past the top.

// File: rtl/stall_trk_pkg.sv
package stall_trk_pkg;

    localparam int NUM_CNT   = 4;
    localparam int IDX_LDST  = 0;
    localparam int IDX_CTIST = 1;
    localparam int IDX_TAKEN = 2;
    localparam int IDX_UNTKN = 3;

    typedef struct packed {
        logic ex;
        logic cmp;
        logic mac;
        logic cti;
        logic ld;
        logic st;
    } unit_t;

endpackage

// File: rtl/stall_unit_decode.sv
module stall_unit_decode
    import stall_trk_pkg::*;
(
    input  unit_t unit,
    output logic  chk_a,
    output logic  chk_b,
    output logic  map_upd,
    output logic  is_load,
    output logic  is_cti
);

    logic two_src;
    logic store_only;

    always_comb begin
        two_src    = unit.ex | unit.cmp | unit.mac;
        store_only = unit.st & ~(two_src | unit.cti | unit.ld);
        chk_a      = two_src | unit.cti;
        chk_b      = two_src;
        map_upd    = ~store_only;
        is_load    = unit.ld;
        is_cti     = unit.cti;
    end

endmodule

// File: rtl/stall_src_hazard.sv
module stall_src_hazard #(
    parameter int NREG  = 16,
    parameter int REG_W = $clog2(NREG)
) (
    input  logic [NREG-1:0] map,
    input  logic [REG_W:0]  src,
    input  logic            en,
    output logic            hit
);

    logic [REG_W-1:0] idx;
    logic             in_range;

    always_comb begin
        idx      = src[REG_W-1:0];
        in_range = (32'(idx) < NREG);
        hit      = en && !src[REG_W] && in_range && map[idx];
    end

endmodule

// File: rtl/stall_sat_add.sv
module stall_sat_add #(
    parameter int W  = 32,
    parameter int IW = 3
) (
    input  logic [W-1:0]  cur,
    input  logic [IW-1:0] inc,
    output logic [W-1:0]  nxt
);

    localparam int WS = W + 1;

    logic [W:0] sum;

    always_comb begin
        sum = {1'b0, cur} + WS'(inc);
        nxt = sum[W] ? {W{1'b1}} : sum[W-1:0];
    end

endmodule

// File: rtl/stall_tracker.sv
module stall_tracker
    import stall_trk_pkg::*;
#(
    parameter int NREG    = 16,
    parameter int CNT_W   = 32,
    parameter int LD_PEN  = 2,
    parameter int CTI_PEN = 2,
    localparam int REG_W   = $clog2(NREG),
    localparam int STALL_W = $clog2(2 * LD_PEN + CTI_PEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               iss_vld,
    input  logic               u_exec,
    input  logic               u_cmp,
    input  logic               u_mac,
    input  logic               u_cti,
    input  logic               u_load,
    input  logic               u_store,
    input  logic               cti_taken,
    input  logic [REG_W:0]     src_a,
    input  logic [REG_W:0]     src_b,
    input  logic [REG_W-1:0]   ld_dst,
    output logic               stall_vld,
    output logic [STALL_W-1:0] stall_cyc,
    output logic [NREG-1:0]    pend_map,
    output logic [NREG-1:0]    act_map,
    output logic [CNT_W-1:0]   ld_stall_cnt,
    output logic [CNT_W-1:0]   cti_stall_cnt,
    output logic [CNT_W-1:0]   taken_cnt,
    output logic [CNT_W-1:0]   untaken_cnt
);

    localparam int NSRC = 2;

    typedef struct packed {
        logic [NREG-1:0]                  pend;
        logic [NREG-1:0]                  act;
        logic                             vld;
        logic [STALL_W-1:0]               stall;
        logic [NUM_CNT-1:0][CNT_W-1:0]    cnt;
    } state_t;

    state_t st_d, st_q;

    unit_t unit;
    logic  chk_a, chk_b, map_upd, is_load, is_cti;

    assign unit = '{ex: u_exec, cmp: u_cmp, mac: u_mac,
                    cti: u_cti, ld: u_load, st: u_store};

    stall_unit_decode u_dec (
        .unit    (unit),
        .chk_a   (chk_a),
        .chk_b   (chk_b),
        .map_upd (map_upd),
        .is_load (is_load),
        .is_cti  (is_cti)
    );

    // Hazard test of each source against the loads of the previous
    // non-store instruction.
    logic [NSRC-1:0][REG_W:0] src_f;
    logic [NSRC-1:0]          src_en;
    logic [NSRC-1:0]          src_hit;

    assign src_f  = {src_b, src_a};
    assign src_en = {chk_b, chk_a};

    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            stall_src_hazard #(.NREG(NREG), .REG_W(REG_W)) u_haz (
                .map (st_q.pend),
                .src (src_f[s]),
                .en  (src_en[s]),
                .hit (src_hit[s])
            );
        end
    endgenerate

    logic [STALL_W-1:0] n_hits;
    logic [STALL_W-1:0] ld_pen_amt;
    logic [STALL_W-1:0] cti_pen_amt;
    logic               taken_ev;
    logic               untaken_ev;

    always_comb begin
        n_hits      = STALL_W'(src_hit[0]) + STALL_W'(src_hit[1]);
        ld_pen_amt  = n_hits * STALL_W'(LD_PEN);
        taken_ev    = is_cti & cti_taken;
        untaken_ev  = is_cti & ~cti_taken;
        cti_pen_amt = taken_ev ? STALL_W'(CTI_PEN) : '0;
    end

    // Saturating counters, one adder per counter.
    logic [NUM_CNT-1:0][STALL_W-1:0] cnt_inc;
    logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_nxt;

    always_comb begin
        cnt_inc            = '0;
        cnt_inc[IDX_LDST]  = ld_pen_amt;
        cnt_inc[IDX_CTIST] = cti_pen_amt;
        cnt_inc[IDX_TAKEN] = STALL_W'(taken_ev);
        cnt_inc[IDX_UNTKN] = STALL_W'(untaken_ev);
    end

    generate
        for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
            stall_sat_add #(.W(CNT_W), .IW(STALL_W)) u_sat (
                .cur (st_q.cnt[k]),
                .inc (cnt_inc[k]),
                .nxt (cnt_nxt[k])
            );
        end
    endgenerate

    logic [NREG-1:0] dst_bit;

    always_comb begin
        dst_bit = '0;
        if (32'(ld_dst) < NREG) begin
            dst_bit[ld_dst] = 1'b1;
        end
    end

    // Next-state process.
    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (clr) begin
            st_d = '0;
        end else if (iss_vld) begin
            st_d.vld   = 1'b1;
            st_d.stall = ld_pen_amt + cti_pen_amt;
            if (map_upd) begin
                st_d.act  = st_q.pend;
                st_d.pend = is_load ? dst_bit : '0;
            end
            st_d.cnt = cnt_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stall_vld     = st_q.vld;
    assign stall_cyc     = st_q.stall;
    assign pend_map      = st_q.pend;
    assign act_map       = st_q.act;
    assign ld_stall_cnt  = st_q.cnt[IDX_LDST];
    assign cti_stall_cnt = st_q.cnt[IDX_CTIST];
    assign taken_cnt     = st_q.cnt[IDX_TAKEN];
    assign untaken_cnt   = st_q.cnt[IDX_UNTKN];

endmodule

// File: rtl/stall_trk_chk.sv
module stall_trk_chk #(
    parameter int NREG    = 16,
    parameter int CNT_W   = 32,
    parameter int LD_PEN  = 2,
    parameter int CTI_PEN = 2,
    parameter int REG_W   = 4,
    parameter int STALL_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr,
    input logic               iss_vld,
    input logic               u_exec,
    input logic               u_cmp,
    input logic               u_mac,
    input logic               u_cti,
    input logic               u_load,
    input logic               u_store,
    input logic               cti_taken,
    input logic [REG_W:0]     src_a,
    input logic [REG_W:0]     src_b,
    input logic               stall_vld,
    input logic [STALL_W-1:0] stall_cyc,
    input logic [NREG-1:0]    pend_map,
    input logic [NREG-1:0]    act_map,
    input logic [CNT_W-1:0]   ld_stall_cnt,
    input logic [CNT_W-1:0]   cti_stall_cnt,
    input logic [CNT_W-1:0]   taken_cnt,
    input logic [CNT_W-1:0]   untaken_cnt
);

    logic store_only;
    assign store_only = u_store & ~(u_exec | u_cmp | u_mac | u_cti | u_load);

    AST_PEND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_map)); // R1

    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        stall_vld |-> (32'(stall_cyc) <= 2 * LD_PEN + CTI_PEN)); // R2

    AST_NONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && !clr && src_a[REG_W] && src_b[REG_W] && !u_cti)
        |=> (stall_cyc == '0)); // R3

    AST_UNTAKEN_NOSTALL: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && !clr && u_cti && !cti_taken) |=> $stable(cti_stall_cnt)); // R5

    AST_STORE_KEEPS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && !clr && store_only)
        |=> ($stable(pend_map) && $stable(act_map))); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!iss_vld && !clr)
        |=> (!stall_vld && $stable(pend_map) && $stable(ld_stall_cnt)
             && $stable(taken_cnt) && $stable(untaken_cnt))); // R8

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (ld_stall_cnt >= $past(ld_stall_cnt)
                  && cti_stall_cnt >= $past(cti_stall_cnt)
                  && taken_cnt >= $past(taken_cnt)
                  && untaken_cnt >= $past(untaken_cnt))); // R9

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ld_stall_cnt == '0 && cti_stall_cnt == '0 && taken_cnt == '0
                 && untaken_cnt == '0 && pend_map == '0 && act_map == '0
                 && !stall_vld)); // R10

    AST_ISSUE_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && !clr) |=> stall_vld); // R12

endmodule

bind stall_tracker stall_trk_chk #(
    .NREG(NREG), .CNT_W(CNT_W), .LD_PEN(LD_PEN), .CTI_PEN(CTI_PEN),
    .REG_W(REG_W), .STALL_W(STALL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .iss_vld(iss_vld),
    .u_exec(u_exec), .u_cmp(u_cmp), .u_mac(u_mac), .u_cti(u_cti),
    .u_load(u_load), .u_store(u_store), .cti_taken(cti_taken),
    .src_a(src_a), .src_b(src_b),
    .stall_vld(stall_vld), .stall_cyc(stall_cyc),
    .pend_map(pend_map), .act_map(act_map),
    .ld_stall_cnt(ld_stall_cnt), .cti_stall_cnt(cti_stall_cnt),
    .taken_cnt(taken_cnt), .untaken_cnt(untaken_cnt)
);

// File: tb/sim_stall_tracker.sv
module sim_stall_tracker;

    localparam int CLK_PERIOD = 10;
    localparam int NREG  = 16;
    localparam int CNT_W = 6;
    localparam int CMAX  = (1 << CNT_W) - 1;
    localparam logic [4:0] NONE = 5'b11111;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       iss_vld = 1'b0;
    logic       u_exec = 1'b0, u_cmp = 1'b0, u_mac = 1'b0;
    logic       u_cti = 1'b0, u_load = 1'b0, u_store = 1'b0;
    logic       cti_taken = 1'b0;
    logic [4:0] src_a = NONE, src_b = NONE;
    logic [3:0] ld_dst = '0;
    logic             stall_vld;
    logic [2:0]       stall_cyc;
    logic [NREG-1:0]  pend_map, act_map;
    logic [CNT_W-1:0] ld_stall_cnt, cti_stall_cnt, taken_cnt, untaken_cnt;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stall_tracker #(.NREG(NREG), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .iss_vld(iss_vld),
        .u_exec(u_exec), .u_cmp(u_cmp), .u_mac(u_mac), .u_cti(u_cti),
        .u_load(u_load), .u_store(u_store), .cti_taken(cti_taken),
        .src_a(src_a), .src_b(src_b), .ld_dst(ld_dst),
        .stall_vld(stall_vld), .stall_cyc(stall_cyc),
        .pend_map(pend_map), .act_map(act_map),
        .ld_stall_cnt(ld_stall_cnt), .cti_stall_cnt(cti_stall_cnt),
        .taken_cnt(taken_cnt), .untaken_cnt(untaken_cnt)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench model of the requirements.
    logic [NREG-1:0] m_pend = '0, m_act = '0;
    int m_ld = 0, m_cs = 0, m_tk = 0, m_ut = 0;

    function automatic int sat(input int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_cnts(input string tag);
        chk({tag, " ld_stall_cnt"},  64'(ld_stall_cnt),  64'(m_ld));
        chk({tag, " cti_stall_cnt"}, 64'(cti_stall_cnt), 64'(m_cs));
        chk({tag, " taken_cnt"},     64'(taken_cnt),     64'(m_tk));
        chk({tag, " untaken_cnt"},   64'(untaken_cnt),   64'(m_ut));
    endtask

    function automatic bit hits_src(input logic [4:0] s);
        return !s[4] && m_pend[s[3:0]];
    endfunction

    task automatic issue(input bit ex, input bit cm, input bit mc, input bit ct,
                         input bit ld, input bit st, input bit tk,
                         input logic [4:0] a, input logic [4:0] b,
                         input logic [3:0] d, input string tag);
        int hits;
        int exp_stall;
        bit two;
        bit st_only;
        two     = ex | cm | mc;
        st_only = st && !(two || ct || ld);
        hits    = 0;
        if ((two || ct) && hits_src(a)) hits++;
        if (two && hits_src(b)) hits++;
        exp_stall = 2 * hits + ((ct && tk) ? 2 : 0);
        m_ld = sat(m_ld + 2 * hits);
        if (ct && tk) begin
            m_cs = sat(m_cs + 2);
            m_tk = sat(m_tk + 1);
        end
        if (ct && !tk) m_ut = sat(m_ut + 1);
        if (!st_only) begin
            m_act  = m_pend;
            m_pend = ld ? (NREG'(1) << d) : '0;
        end
        u_exec = ex; u_cmp = cm; u_mac = mc; u_cti = ct;
        u_load = ld; u_store = st; cti_taken = tk;
        src_a = a; src_b = b; ld_dst = d; iss_vld = 1'b1;
        @(posedge clk);
        #1;
        iss_vld = 1'b0;
        u_exec = 0; u_cmp = 0; u_mac = 0; u_cti = 0; u_load = 0; u_store = 0;
        chk("R12 stall_vld", 64'(stall_vld), 64'd1);
        chk({tag, " stall_cyc"}, 64'(stall_cyc), 64'(exp_stall));
        chk(st_only ? "R6 pend_map" : "R1 pend_map", 64'(pend_map), 64'(m_pend));
        chk(st_only ? "R6 act_map" : "R1 act_map", 64'(act_map), 64'(m_act));
        chk_cnts(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            chk("R8 stall_vld", 64'(stall_vld), 64'd0);
            chk("R8 pend_map", 64'(pend_map), 64'(m_pend));
            chk_cnts("R8");
        end
    endtask

    task automatic do_clear();
        clr = 1'b1;
        iss_vld = 1'b1; u_load = 1'b1; ld_dst = 4'd5;
        u_cti = 1'b1; cti_taken = 1'b1;
        @(posedge clk);
        #1;
        clr = 1'b0; iss_vld = 1'b0; u_load = 1'b0; u_cti = 1'b0;
        m_pend = '0; m_act = '0; m_ld = 0; m_cs = 0; m_tk = 0; m_ut = 0;
        chk("R10 stall_vld", 64'(stall_vld), 64'd0);
        chk("R10 pend_map", 64'(pend_map), 64'd0);
        chk("R10 act_map", 64'(act_map), 64'd0);
        chk_cnts("R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        chk("R11 stall_vld", 64'(stall_vld), 64'd0);
        chk("R11 pend_map", 64'(pend_map), 64'd0);
        chk("R11 act_map", 64'(act_map), 64'd0);
        chk_cnts("R11");

        // R2/R3: load each register, exec consumer on every source value.
        for (int d = 0; d < NREG; d++) begin
            for (int s = 0; s <= NREG; s++) begin
                logic [4:0] sv;
                sv = (s == NREG) ? NONE : 5'(s);
                issue(0,0,0,0,1,0,0, NONE, NONE, 4'(d), "R1 load");
                issue(1,0,0,0,0,0,0, sv, NONE, 4'd0, (s == NREG) ? "R3" : "R2");
            end
            do_clear();
        end

        // R2/R4: two-source units, both fields tested independently.
        for (int d = 0; d < NREG; d++) begin
            for (int s = 0; s < NREG; s++) begin
                issue(0,0,0,0,1,0,0, NONE, NONE, 4'(d), "R1 load");
                if (s[0]) issue(0,0,1,0,0,0,0, 5'(d), 5'(s), 4'd0, "R2 mac");
                else      issue(0,1,0,0,0,0,0, 5'(s), 5'(d), 4'd0, "R4 cmp");
            end
            do_clear();
        end

        // R3: "none" with other low bits also never stalls.
        issue(0,0,0,0,1,0,0, NONE, NONE, 4'd0, "R1 load");
        issue(1,0,0,0,0,0,0, 5'b10000, 5'b10000, 4'd0, "R3");

        // R4: control transfer checks only src_a; load and store check none.
        for (int tk = 0; tk < 2; tk++) begin
            for (int s = 0; s < NREG; s++) begin
                issue(0,0,0,0,1,0,0, NONE, NONE, 4'd7, "R1 load");
                issue(0,0,0,1,0,0,tk[0], 5'(s), 5'd7, 4'd0, "R5 cti");
            end
        end
        do_clear();
        issue(0,0,0,0,1,0,0, NONE, NONE, 4'd3, "R1 load");
        issue(0,0,0,0,1,0,0, 5'd3, 5'd3, 4'd9, "R4 load-consumer");
        issue(0,0,0,0,0,1,0, 5'd9, 5'd9, 4'd0, "R4 store-consumer");

        // R6: stores keep the window open.
        issue(0,0,0,0,1,0,0, NONE, NONE, 4'd4, "R1 load");
        issue(0,0,0,0,0,1,0, 5'd4, NONE, 4'd0, "R6 store");
        issue(0,0,0,0,0,1,0, NONE, 5'd4, 4'd0, "R6 store");
        issue(1,0,0,0,0,0,0, 5'd4, NONE, 4'd0, "R6 use after stores");

        // R7: window is one instruction.
        issue(0,0,0,0,1,0,0, NONE, NONE, 4'd12, "R1 load");
        issue(1,0,0,0,0,0,0, 5'd1, NONE, 4'd0, "R7 first");
        issue(1,0,0,0,0,0,0, 5'd12, 5'd12, 4'd0, "R7 second");

        // R8: idle cycles do not disturb the window.
        issue(0,0,0,0,1,0,0, NONE, NONE, 4'd6, "R1 load");
        idle(3);
        issue(0,1,0,0,0,0,0, 5'd6, NONE, 4'd0, "R8 use after idle");

        // R9: saturation of every counter.
        do_clear();
        for (int i = 0; i < 70; i++) begin
            issue(0,0,0,0,1,0,0, NONE, NONE, 4'd2, "R1 load");
            issue(0,0,0,1,0,0,1, 5'd2, NONE, 4'd0, "R9 taken");
            issue(0,0,0,1,0,0,0, NONE, NONE, 4'd0, "R9 untaken");
        end
        chk("R9 taken at top", 64'(taken_cnt), 64'(CMAX));
        chk("R9 untaken at top", 64'(untaken_cnt), 64'(CMAX));
        chk("R9 cti stall at top", 64'(cti_stall_cnt), 64'(CMAX));
        chk("R9 ld stall at top", 64'(ld_stall_cnt), 64'(CMAX));

        // R10: clear wins over a simultaneous issue.
        do_clear();
        idle(1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule